// File: doc/BRIEF.md
# Shared-Pin General-Purpose I/O Port

This block is an eight-pin bidirectional port with a software-visible output latch, a per-pin direction register and a per-pin pull-up enable. A small register bus writes these registers and reads the port. Each pin drives its pad from the latch when it is set as an output. When it is set as an input, the block samples the pad through a two-flop synchronizer. A port read returns the synchronized pad level for input pins and the latch value for output pins.

Three alternate functions can take over fixed pins. A complementary buzzer pair on pins 0 and 1 drives an externally generated tone and its inverse. An external interrupt input on pin 2 detects falling edges. An external timer clock input on pin 3 emits one-cycle pulses on rising edges. Each takeover is selected by a bit or field in an option register. When a function is not selected, its pin behaves as ordinary I/O. Only the tone input, the interrupt request and the timer pulse are modelled here. The tone generator, the interrupt controller and the timer counter are outside this block.

Top module: `pin_share_port`

## Requirements
- R1: After reset the direction register reads 8'hFF, and the latch, pull-up, option and flag registers read 0. All padOe bits and all pullEn bits are 0.
- R2: A pin whose direction bit is 0 (output) and that is not taken over has padOe=1 and padOut equal to its latch bit. A direction bit of 1 (input) gives padOe=0.
- R3: A read of address 0 returns, for each pin, the pad level two clocks after it was applied if the pin is an input, or the latch bit if the pin is driven.
- R4: pullEn for a pin equals its pull-up register bit (address 2) while the pin is an input, and is 0 while the pin is driven.
- R5: With option bit 0 set (buzzer), pins 0 and 1 are driven whatever their direction bits hold: padOut[0]=toneIn and padOut[1]=~toneIn. Port reads of these two pins return their latch bits.
- R6: With option bit 1 set (interrupt enable), a falling edge on synchronized pad 2 gives exactly one cycle of irqPulse and sets irqFlag, which reads back as bit 0 of address 4. With the bit clear, no pulse occurs and pin 2 is ordinary I/O.
- R7: Writing a value with bit 0 set to address 4 clears irqFlag.
- R8: With option bits [3:2]=2'b10 (external timer clock), each rising edge on synchronized pad 3 gives exactly one cycle of tmrPulse. Every other value of this field gives no pulses and leaves pin 3 as ordinary I/O.
- R9: A pin taken over as interrupt or timer input has padOe=0 whatever its direction bit holds, and a port read returns its synchronized pad level.
- R10: Addresses 1, 2 and 3 read back the direction, pull-up and option registers as written. The option register holds 4 bits and its upper read bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 port, 1 direction, 2 pull-up, 3 option, 4 flag) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| padIn | input | 8 | Pad input levels |
| toneIn | input | 1 | Buzzer tone from the tone generator |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| pullEn | output | 8 | Pad pull-up enables |
| irqPulse | output | 1 | One-cycle interrupt request |
| irqFlag | output | 1 | Held interrupt flag |
| tmrPulse | output | 1 | One-cycle timer clock pulse |

## Verification
A corrupt direction or option bit shows up in the same cycle as a wrong padOe, pullEn or padOut bit. A port read of the affected pin also returns the latch where it should return the pad, or the pad where it should return the latch. A synchronizer or edge-history fault shows as an extra, missing or mistimed irqPulse or tmrPulse within three clocks of a pad change. A flag fault persists at irqFlag until the next clear write, so it can be observed at any later read of address 4.

// File: rtl/pin_share_pkg.sv
package pin_share_pkg;
  localparam int ADDR_W = 3;
  localparam int OPT_W = 4;
  localparam int OPT_BZ = 0;
  localparam int OPT_INT = 1;
  localparam int OPT_TMR_LO = 2;
  localparam logic [1:0] TMR_EXT = 2'b10;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT = 3'd0,
    REG_DIR  = 3'd1,
    REG_PULL = 3'd2,
    REG_OPT  = 3'd3,
    REG_FLAG = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic wrLatch;
    logic wrDir;
    logic wrPull;
    logic wrOpt;
    logic clrFlag;
  } strobe_t;
endpackage

// File: rtl/pin_share_sync.sv
module pin_share_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stg[s] <= '0;
      end else if (s == 0) begin
        stg[s] <= d;
      end else begin
        stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pin_share_ctrl.sv
module pin_share_ctrl
  import pin_share_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWrData,
  input  logic [WIDTH-1:0]  portRd,
  input  logic [WIDTH-1:0]  dirVal,
  input  logic [WIDTH-1:0]  pullVal,
  input  logic [OPT_W-1:0]  optVal,
  input  logic              flagVal,
  output strobe_t           strobes,
  output logic [WIDTH-1:0]  regRdData
);
  always_comb begin
    strobes = '0;
    if (regWe) begin
      case (regAddr)
        REG_PORT: strobes.wrLatch = 1'b1;
        REG_DIR:  strobes.wrDir   = 1'b1;
        REG_PULL: strobes.wrPull  = 1'b1;
        REG_OPT:  strobes.wrOpt   = 1'b1;
        REG_FLAG: strobes.clrFlag = regWrData[0];
        default:  strobes = '0;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_PORT: regRdData = portRd;
      REG_DIR:  regRdData = dirVal;
      REG_PULL: regRdData = pullVal;
      REG_OPT:  regRdData[OPT_W-1:0] = optVal;
      REG_FLAG: regRdData[0] = flagVal;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/pin_share_dp.sv
module pin_share_dp
  import pin_share_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BZ_PIN = 0,
  parameter int INT_PIN = 2,
  parameter int TMR_PIN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  input  logic             toneIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] pullEn,
  output logic             irqPulse,
  output logic             irqFlag,
  output logic             tmrPulse,
  output logic [WIDTH-1:0] portRd,
  output logic [WIDTH-1:0] dirVal,
  output logic [WIDTH-1:0] pullVal,
  output logic [OPT_W-1:0] optVal
);
  logic [WIDTH-1:0] latchQ, dirQ, pullQ, syncQ, prevQ;
  logic [OPT_W-1:0] optQ;
  logic flagQ;
  logic bzEn, intEn, tmrExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '1;
      pullQ  <= '0;
      optQ   <= '0;
    end else begin
      if (strobes.wrLatch) latchQ <= wrData;
      if (strobes.wrDir)   dirQ   <= wrData;
      if (strobes.wrPull)  pullQ  <= wrData;
      if (strobes.wrOpt)   optQ   <= wrData[OPT_W-1:0];
    end
  end

  pin_share_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .d(padIn), .q(syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncQ;
  end

  assign bzEn   = optQ[OPT_BZ];
  assign intEn  = optQ[OPT_INT];
  assign tmrExt = (optQ[OPT_TMR_LO+1:OPT_TMR_LO] == TMR_EXT);

  assign irqPulse = intEn && prevQ[INT_PIN] && !syncQ[INT_PIN];
  assign tmrPulse = tmrExt && !prevQ[TMR_PIN] && syncQ[TMR_PIN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          flagQ <= 1'b0;
    else if (irqPulse)  flagQ <= 1'b1;
    else if (strobes.clrFlag) flagQ <= 1'b0;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    localparam bit IS_BZ_A = (i == BZ_PIN);
    localparam bit IS_BZ_B = (i == BZ_PIN + 1);
    localparam bit IS_INT  = (i == INT_PIN);
    localparam bit IS_TMR  = (i == TMR_PIN);
    logic bzHere, altIn, effIn;

    assign bzHere = (IS_BZ_A || IS_BZ_B) && bzEn;
    assign altIn  = (IS_INT && intEn) || (IS_TMR && tmrExt);
    assign effIn  = altIn || (dirQ[i] && !bzHere);

    assign padOe[i]  = !effIn;
    assign pullEn[i] = pullQ[i] && effIn;
    assign padOut[i] = (IS_BZ_A && bzEn) ? toneIn :
                       (IS_BZ_B && bzEn) ? !toneIn : latchQ[i];
    assign portRd[i] = effIn ? syncQ[i] : latchQ[i];
  end

  assign irqFlag = flagQ;
  assign dirVal  = dirQ;
  assign pullVal = pullQ;
  assign optVal  = optQ;
endmodule

// File: rtl/pin_share_port.sv
module pin_share_port
  import pin_share_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BZ_PIN = 0,
  parameter int INT_PIN = 2,
  parameter int TMR_PIN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWrData,
  output logic [WIDTH-1:0]  regRdData,
  input  logic [WIDTH-1:0]  padIn,
  input  logic              toneIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  pullEn,
  output logic              irqPulse,
  output logic              irqFlag,
  output logic              tmrPulse
);
  strobe_t strobes;
  logic [WIDTH-1:0] portRd, dirVal, pullVal;
  logic [OPT_W-1:0] optVal;

  pin_share_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
    .portRd(portRd), .dirVal(dirVal), .pullVal(pullVal),
    .optVal(optVal), .flagVal(irqFlag),
    .strobes(strobes), .regRdData(regRdData)
  );

  pin_share_dp #(
    .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES),
    .BZ_PIN(BZ_PIN), .INT_PIN(INT_PIN), .TMR_PIN(TMR_PIN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .padIn(padIn), .toneIn(toneIn),
    .padOut(padOut), .padOe(padOe), .pullEn(pullEn),
    .irqPulse(irqPulse), .irqFlag(irqFlag), .tmrPulse(tmrPulse),
    .portRd(portRd), .dirVal(dirVal), .pullVal(pullVal), .optVal(optVal)
  );
endmodule

// File: rtl/pin_share_chk.sv
module pin_share_chk
  import pin_share_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int BZ_PIN = 0,
  parameter int INT_PIN = 2,
  parameter int TMR_PIN = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] padOut,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] pullEn,
  input logic             irqPulse,
  input logic             irqFlag,
  input logic             tmrPulse,
  input logic [OPT_W-1:0] optVal
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R6
  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> irqFlag); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    !optVal[OPT_INT] |-> !irqPulse); // R6
  AST_TMR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    tmrPulse |=> !tmrPulse); // R8
  AST_TMR_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (optVal[OPT_TMR_LO+1:OPT_TMR_LO] != TMR_EXT) |-> !tmrPulse); // R8
  AST_BZ_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    optVal[OPT_BZ] |-> (padOe[BZ_PIN] && padOe[BZ_PIN+1] &&
                        padOut[BZ_PIN+1] == !padOut[BZ_PIN])); // R5
  AST_ALT_INPUT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    optVal[OPT_INT] |-> !padOe[INT_PIN]); // R9
  AST_PULL_ONLY_IN: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & pullEn) == '0); // R4
  AST_TMR_INPUT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (optVal[OPT_TMR_LO+1:OPT_TMR_LO] == TMR_EXT) |-> !padOe[TMR_PIN]); // R9
endmodule

bind pin_share_port pin_share_chk #(
  .WIDTH(WIDTH), .BZ_PIN(BZ_PIN), .INT_PIN(INT_PIN), .TMR_PIN(TMR_PIN)
) chk_i (
  .clk(clk), .rstN(rstN), .padOut(padOut), .padOe(padOe), .pullEn(pullEn),
  .irqPulse(irqPulse), .irqFlag(irqFlag), .tmrPulse(tmrPulse), .optVal(optVal)
);

// File: tb/pin_share_port_tb_top.sv
`timescale 1ns/1ps
module pin_share_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] padIn = '0;
  logic toneIn = 1'b0;
  logic [7:0] padOut, padOe, pullEn;
  logic irqPulse, irqFlag, tmrPulse;

  int nTests = 0;
  int nFail = 0;
  int irqCount = 0;
  int tmrCount = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_share_port dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .padIn(padIn),
    .toneIn(toneIn), .padOut(padOut), .padOe(padOe), .pullEn(pullEn),
    .irqPulse(irqPulse), .irqFlag(irqFlag), .tmrPulse(tmrPulse)
  );

  always @(negedge clk) begin
    cycles++;
    if (rstN && irqPulse) irqCount++;
    if (rstN && tmrPulse) tmrCount++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd, lat, pad;
    int c0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R1 reset state
    rdReg(3'd1, rd); check("R1 dir", rd, 8'hFF);
    rdReg(3'd0, rd); check("R1 port", rd, 8'h00);
    rdReg(3'd2, rd); check("R1 pull", rd, 8'h00);
    rdReg(3'd3, rd); check("R1 opt", rd, 8'h00);
    rdReg(3'd4, rd); check("R1 flag", rd, 8'h00);
    check("R1 oe", padOe, 8'h00);
    check("R1 pullEn", pullEn, 8'h00);

    // R2 R3 R4 sweep over every direction value
    wrReg(3'd2, 8'hFF);
    for (int d = 0; d < 256; d++) begin
      lat = 8'(d) ^ 8'h5A;
      pad = 8'(d * 37 + 11);
      padIn = pad;
      wrReg(3'd0, lat);
      wrReg(3'd1, 8'(d));
      waitCyc(2);
      check("R2 oe", padOe, ~8'(d));
      check("R2 out", padOut, lat);
      check("R4 pullEn", pullEn, 8'(d));
      rdReg(3'd0, rd);
      check("R3 port read", rd, (8'(d) & pad) | (~8'(d) & lat));
    end

    // R10 register readback
    wrReg(3'd1, 8'hA5); rdReg(3'd1, rd); check("R10 dir", rd, 8'hA5);
    wrReg(3'd2, 8'h3C); rdReg(3'd2, rd); check("R10 pull", rd, 8'h3C);
    wrReg(3'd3, 8'hF6); rdReg(3'd3, rd); check("R10 opt", rd, 8'h06);
    wrReg(3'd3, 8'h00);

    // R5 buzzer pair
    padIn = 8'hFF;
    wrReg(3'd1, 8'hFF);
    wrReg(3'd0, 8'h00);
    wrReg(3'd3, 8'h01);
    for (int t = 0; t < 2; t++) begin
      toneIn = t[0];
      waitCyc(3);
      check("R5 oe", padOe & 8'h03, 8'h03);
      check("R5 out", padOut & 8'h03, {6'b0, ~t[0], t[0]});
      rdReg(3'd0, rd);
      check("R5 read latch", rd, 8'hFC);
    end
    wrReg(3'd3, 8'h00);
    toneIn = 1'b0;

    // R6 R9 interrupt input
    padIn = 8'h00;
    wrReg(3'd0, 8'h00);
    wrReg(3'd1, 8'h00);
    wrReg(3'd3, 8'h02);
    check("R9 int oe", padOe & 8'h04, 8'h00);
    c0 = irqCount;
    padIn = 8'h04;
    waitCyc(4);
    check("R6 no pulse on rise", 8'(irqCount - c0), 8'd0);
    rdReg(3'd0, rd); check("R9 int read pad", rd, 8'h04);
    padIn = 8'h00;
    waitCyc(4);
    check("R6 one pulse on fall", 8'(irqCount - c0), 8'd1);
    check("R6 flag", {7'b0, irqFlag}, 8'h01);
    rdReg(3'd4, rd); check("R6 flag read", rd, 8'h01);
    wrReg(3'd4, 8'h01);
    check("R7 flag cleared", {7'b0, irqFlag}, 8'h00);
    rdReg(3'd4, rd); check("R7 flag read", rd, 8'h00);

    wrReg(3'd3, 8'h00);
    c0 = irqCount;
    padIn = 8'h04; waitCyc(4);
    padIn = 8'h00; waitCyc(4);
    check("R6 disabled no pulse", 8'(irqCount - c0), 8'd0);
    check("R6 disabled flag", {7'b0, irqFlag}, 8'h00);
    check("R6 disabled pin driven", padOe & 8'h04, 8'h04);

    // R8 R9 timer clock input
    wrReg(3'd3, 8'h08);
    check("R9 tmr oe", padOe & 8'h08, 8'h00);
    c0 = tmrCount;
    for (int e = 0; e < 3; e++) begin
      padIn = 8'h08; waitCyc(4);
      padIn = 8'h00; waitCyc(4);
    end
    check("R8 ext three pulses", 8'(tmrCount - c0), 8'd3);
    for (int m = 0; m < 4; m++) begin
      if (m != 2) begin
        wrReg(3'd3, 8'(m << 2));
        c0 = tmrCount;
        padIn = 8'h08; waitCyc(4);
        padIn = 8'h00; waitCyc(4);
        check("R8 internal no pulse", 8'(tmrCount - c0), 8'd0);
        check("R8 internal pin driven", padOe & 8'h08, 8'h08);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule